// File: doc/BRIEF.md
# DAC Ramp Profile Sequencer

This block produces a 10-bit code for a digital-to-analogue converter by replaying a 64-entry profile table. A host first loads the profile (typically a monotonic rise such as a raised-cosine shape) and then asks for a rise, a fall, or a full rise-then-fall. One address step is taken on every clock where the step-rate enable is high, so the ramp duration is set by an external rate divider.

A single control register holds the static output value, a source select, a hold and a reversal policy. With the source select cleared the static value drives the output and the profile table is open for loading. With it set the table's registered read port drives the output and the table is locked. The host port is a plain synchronous register interface with no back-pressure. Every write strobe is accepted on the clock edge where it is seen, and there is no ready signal to wait on. The output code is a continuously valid level, not a stream.

Control register layout: bits 9..0 static value, bits 11..10 reserved (zero), bit 12 source select, bit 13 hold, bit 14 deferred-reversal policy, bit 15 unused (zero).

Top module: `ramp_profile_seq`

## Requirements
- R1: After reset the output code is 0, busy and done are low, and the control readback is 0.
- R2: A table write (write strobe, 6-bit address, 10-bit value) is stored while the source select is 0. With the select at 1 the output shows the table entry at the current address one clock after the address changes, because the table read is registered.
- R3: A rise command from idle loads address 0. Each step-enabled clock adds one. On reaching 63 the ramp ends with done high for exactly that one clock and busy falling with it, unless a further ramp follows. Busy is high from the clock after an accepted command.
- R4: A fall command from idle loads address 63 and steps down by one per step-enabled clock, ending at 0 with a one-clock done.
- R5: A cycle command from idle rises from 0 to 63, then falls back to 0 without a pause, and gives a single done, at the end of the fall.
- R6: Strobes seen together rank cycle over fall over rise. While a ramp runs, a command for the running direction and any cycle command are ignored. Commands are ignored entirely while the source select is 0.
- R7: With the policy bit at 0, an opposite-direction command flips the running ramp on that clock, from its current address. It also ends the rise-then-fall sequence of a cycle command. If the address is already at the far end of the new direction, the ramp completes there.
- R8: With the policy bit at 1, an opposite-direction command is remembered and the running ramp continues. At completion, done pulses and the remembered ramp starts from the end just reached. A remembered fall during the rising half of a cycle is absorbed by the cycle's own fall.
- R9: While the hold bit is 1 the address does not move and no ramp completes. The output code stays frozen, and clearing the bit resumes from the same address.
- R10: Clearing the source select drives the output from the static value one clock after the write. At the next edge it ends any ramp without a done pulse and drops any remembered reversal.
- R11: Table writes made while the source select is 1 leave the table unchanged.
- R12: Control readback returns bits 14..12 and 9..0 as written, and always returns 0 in bits 15, 11 and 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ram_we | input | 1 | Profile table write strobe |
| ram_waddr | input | 6 | Profile table write address |
| ram_wdata | input | 10 | Profile table write value |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 16 | Control register write value |
| ctl_rdata | output | 16 | Control register readback |
| cmd_up | input | 1 | Rise command strobe |
| cmd_down | input | 1 | Fall command strobe |
| cmd_cycle | input | 1 | Rise-then-fall command strobe |
| step_en | input | 1 | Step-rate enable |
| dac_code | output | 10 | Output code to the converter |
| busy | output | 1 | A ramp is active |
| done | output | 1 | One-clock ramp completion pulse |

## Verification
The hardest situations to reach are the reversal corner cases. These include a flip that lands exactly on the far end of the new direction, and a remembered reversal that is replaced or absorbed while a cycle is in its rising half. Each needs a command to land on one particular step while the policy and hold bits hold particular values. Directed sequences place the commands on chosen steps with the step enable held high. A long stretch of seeded random strobes then follows, with sparse commands, frequent step enables and occasional hold and policy rewrites. A cycle-level model in the bench is compared against the outputs on every clock.

// File: rtl/ramp_seq_pkg.sv
package ramp_seq_pkg;
  localparam int CTL_W     = 16;
  localparam int SEL_BIT   = 12;
  localparam int HOLD_BIT  = 13;
  localparam int DEFER_BIT = 14;

  typedef enum logic [1:0] {RS_IDLE = 2'd0, RS_UP = 2'd1, RS_DOWN = 2'd2} ramp_dir_e;

  function automatic ramp_dir_e flip_dir(input ramp_dir_e d);
    return (d == RS_UP) ? RS_DOWN : RS_UP;
  endfunction
endpackage

// File: rtl/ramp_profile_ram.sv
module ramp_profile_ram #(
  parameter int DW = 10,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // registered read port: old contents on a same-edge write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= mem[raddr];
  end
endmodule

// File: rtl/ramp_addr_engine.sv
module ramp_addr_engine
  import ramp_seq_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          hold,
  input  logic          defer,
  input  logic          req_up,
  input  logic          req_down,
  input  logic          req_cycle,
  input  logic          step_en,
  output logic [AW-1:0] addr,
  output logic          busy,
  output logic          done
);
  localparam logic [AW-1:0] TOP_A = '1;
  localparam logic [AW-1:0] BOT_A = '0;

  ramp_dir_e     dir_q, dir_n, pend_q, pend_n, cur;
  logic          cyc_q, cyc_n, pv_q, pv_n, done_n;
  logic [AW-1:0] addr_q, addr_n, end_a;
  logic          r_cyc, r_dn, r_up, opp, fin;

  // priority: cycle over fall over rise
  assign r_cyc = req_cycle;
  assign r_dn  = req_down & ~req_cycle;
  assign r_up  = req_up & ~req_down & ~req_cycle;

  always_comb begin
    dir_n  = dir_q;
    pend_n = pend_q;
    cyc_n  = cyc_q;
    pv_n   = pv_q;
    addr_n = addr_q;
    done_n = 1'b0;
    cur    = dir_q;
    opp    = 1'b0;
    fin    = 1'b0;
    end_a  = TOP_A;
    if (!enable) begin
      dir_n = RS_IDLE;
      cyc_n = 1'b0;
      pv_n  = 1'b0;
    end else if (dir_q == RS_IDLE) begin
      if (r_cyc) begin
        dir_n = RS_UP; addr_n = BOT_A; cyc_n = 1'b1;
      end else if (r_dn) begin
        dir_n = RS_DOWN; addr_n = TOP_A;
      end else if (r_up) begin
        dir_n = RS_UP; addr_n = BOT_A;
      end
    end else begin
      opp = ((dir_q == RS_UP) && r_dn) || ((dir_q == RS_DOWN) && r_up);
      if (opp && !defer) begin
        cur   = flip_dir(dir_q);
        cyc_n = 1'b0;
        pv_n  = 1'b0;
      end else if (opp) begin
        pv_n   = 1'b1;
        pend_n = flip_dir(dir_q);
      end
      end_a = (cur == RS_UP) ? TOP_A : BOT_A;
      if (!hold) begin
        if (addr_q == end_a) begin
          fin = 1'b1;
        end else if (step_en) begin
          addr_n = (cur == RS_UP) ? addr_q + 1'b1 : addr_q - 1'b1;
          fin    = (addr_n == end_a);
        end
      end
      if (fin) begin
        if (cyc_n && (cur == RS_UP)) begin
          cur = RS_DOWN; cyc_n = 1'b0; pv_n = 1'b0;
        end else if (pv_n) begin
          done_n = 1'b1; cur = pend_n; pv_n = 1'b0;
        end else begin
          done_n = 1'b1; cur = RS_IDLE;
        end
      end
      dir_n = cur;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= RS_IDLE;
      pend_q <= RS_UP;
      cyc_q  <= 1'b0;
      pv_q   <= 1'b0;
      addr_q <= '0;
      done   <= 1'b0;
    end else begin
      dir_q  <= dir_n;
      pend_q <= pend_n;
      cyc_q  <= cyc_n;
      pv_q   <= pv_n;
      addr_q <= addr_n;
      done   <= done_n;
    end
  end

  assign addr = addr_q;
  assign busy = (dir_q != RS_IDLE);
endmodule

// File: rtl/ramp_profile_seq.sv
module ramp_profile_seq
  import ramp_seq_pkg::*;
#(
  parameter int DW = 10,
  parameter int AW = 6,
  parameter int RW = CTL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ram_we,
  input  logic [AW-1:0] ram_waddr,
  input  logic [DW-1:0] ram_wdata,
  input  logic          ctl_we,
  input  logic [RW-1:0] ctl_wdata,
  output logic [RW-1:0] ctl_rdata,
  input  logic          cmd_up,
  input  logic          cmd_down,
  input  logic          cmd_cycle,
  input  logic          step_en,
  output logic [DW-1:0] dac_code,
  output logic          busy,
  output logic          done
);
  logic [DW-1:0] data_q, ram_q;
  logic          sel_q, hold_q, defer_q;
  logic [AW-1:0] eng_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      sel_q   <= 1'b0;
      hold_q  <= 1'b0;
      defer_q <= 1'b0;
    end else if (ctl_we) begin
      data_q  <= ctl_wdata[DW-1:0];
      sel_q   <= ctl_wdata[SEL_BIT];
      hold_q  <= ctl_wdata[HOLD_BIT];
      defer_q <= ctl_wdata[DEFER_BIT];
    end
  end

  always_comb begin
    ctl_rdata            = '0;
    ctl_rdata[DW-1:0]    = data_q;
    ctl_rdata[SEL_BIT]   = sel_q;
    ctl_rdata[HOLD_BIT]  = hold_q;
    ctl_rdata[DEFER_BIT] = defer_q;
  end

  ramp_profile_ram #(.DW(DW), .AW(AW)) u_ram (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (ram_we & ~sel_q),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .raddr (eng_addr),
    .rdata (ram_q)
  );

  ramp_addr_engine #(.AW(AW)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (sel_q),
    .hold      (hold_q),
    .defer     (defer_q),
    .req_up    (cmd_up),
    .req_down  (cmd_down),
    .req_cycle (cmd_cycle),
    .step_en   (step_en),
    .addr      (eng_addr),
    .busy      (busy),
    .done      (done)
  );

  assign dac_code = sel_q ? ram_q : data_q;
endmodule

// File: rtl/ramp_profile_seq_chk.sv
module ramp_profile_seq_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sel_q,
  input logic          hold_q,
  input logic          cmd_up,
  input logic          cmd_down,
  input logic          cmd_cycle,
  input logic [AW-1:0] eng_addr,
  input logic          busy,
  input logic          done
);
  localparam logic [AW-1:0] TOP_A = '1;
  localparam logic [AW-1:0] ONE_A = AW'(1);

  // R10: deselecting the table ends any ramp at the next edge
  a_r10_abort: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_q |=> !busy);

  // R9: a held ramp keeps its address
  a_r9_hold_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && busy) |=> (eng_addr == $past(eng_addr)));

  // R6: a ramp only starts after a command strobe
  a_r6_start_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_up || cmd_down || cmd_cycle));

  // R3: completion happens only at an end of the table
  a_r3_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((eng_addr == '0) || (eng_addr == TOP_A)));

  // R3: a running ramp moves by at most one address per clock
  a_r3_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |->
      ((eng_addr == $past(eng_addr)) ||
       (eng_addr == $past(eng_addr) + ONE_A) ||
       (eng_addr == $past(eng_addr) - ONE_A)));
endmodule

bind ramp_profile_seq ramp_profile_seq_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sel_q     (sel_q),
  .hold_q    (hold_q),
  .cmd_up    (cmd_up),
  .cmd_down  (cmd_down),
  .cmd_cycle (cmd_cycle),
  .eng_addr  (eng_addr),
  .busy      (busy),
  .done      (done)
);

// File: tb/ramp_profile_seq_test.sv
`timescale 1ns/1ps
module ramp_profile_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ram_we = 1'b0;
  logic [5:0]  ram_waddr = '0;
  logic [9:0]  ram_wdata = '0;
  logic        ctl_we = 1'b0;
  logic [15:0] ctl_wdata = '0;
  logic [15:0] ctl_rdata;
  logic        cmd_up = 1'b0, cmd_down = 1'b0, cmd_cycle = 1'b0, step_en = 1'b0;
  logic [9:0]  dac_code;
  logic        busy, done;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  ramp_profile_seq uut (
    .clk(clk), .rst_n(rst_n),
    .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .cmd_up(cmd_up), .cmd_down(cmd_down), .cmd_cycle(cmd_cycle), .step_en(step_en),
    .dac_code(dac_code), .busy(busy), .done(done)
  );

  // ---------------- reference model (state: 0 idle, 1 rise, 2 fall)
  logic [9:0] m_ram [64];
  logic [9:0] m_ramq = '0, m_data = '0;
  logic       m_sel = 0, m_hold = 0, m_defer = 0, m_cyc = 0, m_pv = 0, m_done = 0;
  int         m_dir = 0, m_pd = 1;
  logic [5:0] m_addr = '0;

  function automatic logic [15:0] mkctl(input logic sel, input logic hold,
                                         input logic defer, input logic [9:0] d);
    return {1'b0, defer, hold, sel, 2'b00, d};
  endfunction

  function automatic logic [15:0] exp_rdata();
    return mkctl(m_sel, m_hold, m_defer, m_data);
  endfunction

  function automatic logic [9:0] exp_dac();
    return m_sel ? m_ramq : m_data;
  endfunction

  task automatic model_update();
    logic [9:0] nq;
    logic       rc, rd, ru, ncyc, npv, ndone, opp, fin;
    int         nd, npd, cur;
    logic [5:0] na, ea;
    nq = m_ram[m_addr];
    rc = cmd_cycle; rd = cmd_down && !cmd_cycle; ru = cmd_up && !cmd_down && !cmd_cycle;
    nd = m_dir; na = m_addr; ncyc = m_cyc; npv = m_pv; npd = m_pd; ndone = 0;
    if (!m_sel) begin
      nd = 0; ncyc = 0; npv = 0;
    end else if (m_dir == 0) begin
      if (rc)      begin nd = 1; na = 6'd0; ncyc = 1; end
      else if (rd) begin nd = 2; na = 6'd63; end
      else if (ru) begin nd = 1; na = 6'd0; end
    end else begin
      cur = m_dir; fin = 0;
      opp = (m_dir == 1 && rd) || (m_dir == 2 && ru);
      if (opp && !m_defer) begin cur = 3 - m_dir; ncyc = 0; npv = 0; end
      else if (opp) begin npv = 1; npd = 3 - m_dir; end
      ea = (cur == 1) ? 6'd63 : 6'd0;
      if (!m_hold) begin
        if (m_addr == ea) fin = 1;
        else if (step_en) begin
          na = (cur == 1) ? m_addr + 6'd1 : m_addr - 6'd1;
          fin = (na == ea);
        end
      end
      if (fin) begin
        if (ncyc && cur == 1) begin cur = 2; ncyc = 0; npv = 0; end
        else if (npv) begin ndone = 1; cur = npd; npv = 0; end
        else begin ndone = 1; cur = 0; end
      end
      nd = cur;
    end
    if (ram_we && !m_sel) m_ram[ram_waddr] = ram_wdata;
    if (ctl_we) begin
      m_data = ctl_wdata[9:0]; m_sel = ctl_wdata[12];
      m_hold = ctl_wdata[13];  m_defer = ctl_wdata[14];
    end
    m_ramq = nq; m_dir = nd; m_addr = na; m_cyc = ncyc; m_pv = npv; m_pd = npd; m_done = ndone;
  endtask

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all(input string tag);
    check(tag, "dac_code", int'(dac_code), int'(exp_dac()));
    check(tag, "busy", int'(busy), int'(m_dir != 0));
    check(tag, "done", int'(done), int'(m_done));
    check(tag, "ctl_rdata", int'(ctl_rdata), int'(exp_rdata()));
  endtask

  // one clock: edge, model, sample at the falling edge, release strobes
  task automatic tick(input string tag);
    @(posedge clk);
    model_update();
    @(negedge clk);
    compare_all(tag);
    ram_we = 0; ctl_we = 0; cmd_up = 0; cmd_down = 0; cmd_cycle = 0;
  endtask

  task automatic ctl_write(input logic [15:0] v, input string tag);
    ctl_we = 1; ctl_wdata = v; tick(tag);
  endtask

  task automatic run_idle(input string tag, input int cap);
    for (int i = 0; i < cap && m_dir != 0; i++) tick(tag);
  endtask

  // ---------------- watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R3 watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [9:0] frozen;
    int seen_done;
    void'($urandom(32'd983));
    for (int i = 0; i < 64; i++) m_ram[i] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "dac_code", int'(dac_code), 0);
    check("R1", "busy", int'(busy), 0);
    check("R1", "done", int'(done), 0);
    check("R1", "ctl_rdata", int'(ctl_rdata), 0);
    rst_n = 1;
    @(negedge clk);

    // R2: load a monotonic profile while deselected
    for (int i = 0; i < 64; i++) begin
      ram_we = 1; ram_waddr = 6'(i); ram_wdata = 10'((i * i * 1023) / 3969);
      tick("R2");
    end
    // R12: readback masks reserved bits
    ctl_write(16'hFFFF, "R12");
    check("R12", "reserved", int'(ctl_rdata), 16'h73FF);
    ctl_write(mkctl(0, 0, 0, 10'h155), "R10");
    check("R10", "static out", int'(dac_code), 10'h155);
    // R6: commands ignored while deselected
    cmd_up = 1; tick("R6");
    check("R6", "busy deselected", int'(busy), 0);

    ctl_write(mkctl(1, 0, 0, 10'h155), "R2");
    step_en = 1;
    // R3: full rise
    cmd_up = 1; tick("R3");
    seen_done = 0;
    for (int i = 0; i < 80 && m_dir != 0; i++) begin tick("R3"); if (done) seen_done++; end
    tick("R2");
    check("R3", "done count", seen_done, 1);
    check("R2", "top entry", int'(dac_code), 1023);
    // R4: full fall
    cmd_down = 1; tick("R4"); run_idle("R4", 80); tick("R4");
    check("R4", "bottom entry", int'(dac_code), 0);
    // R5 and R6: all strobes together start a cycle; a rise during it is ignored
    cmd_up = 1; cmd_down = 1; cmd_cycle = 1; tick("R6");
    repeat (5) tick("R5");
    cmd_up = 1; tick("R6");
    seen_done = 0;
    for (int i = 0; i < 200 && m_dir != 0; i++) begin tick("R5"); if (done) seen_done++; end
    check("R5", "single done", seen_done, 1);
    // R7: immediate flip mid-rise, and flip at the far end
    cmd_up = 1; tick("R7"); repeat (10) tick("R7");
    cmd_down = 1; tick("R7"); run_idle("R7", 80);
    cmd_up = 1; tick("R7"); cmd_down = 1; tick("R7"); run_idle("R7", 10);
    check("R7", "flip at end idle", int'(busy), 0);
    // R8: deferred flip, replaced pending, pending during cycle rise
    ctl_write(mkctl(1, 0, 1, 10'h155), "R8");
    cmd_up = 1; tick("R8"); repeat (5) tick("R8");
    cmd_down = 1; tick("R8"); repeat (3) tick("R8"); cmd_down = 1; tick("R8");
    run_idle("R8", 200);
    cmd_cycle = 1; tick("R8"); repeat (4) tick("R8"); cmd_down = 1; tick("R8");
    run_idle("R8", 200);
    // R9: hold freezes the output
    ctl_write(mkctl(1, 0, 0, 10'h155), "R9");
    cmd_up = 1; tick("R9"); repeat (20) tick("R9");
    ctl_write(mkctl(1, 1, 0, 10'h155), "R9");
    tick("R9");
    frozen = dac_code;
    for (int i = 0; i < 10; i++) begin
      tick("R9");
      check("R9", "frozen", int'(dac_code), int'(frozen));
    end
    ctl_write(mkctl(1, 0, 0, 10'h155), "R9");
    repeat (4) tick("R9");
    // R11: writes while selected are dropped
    ram_we = 1; ram_waddr = 6'd63; ram_wdata = 10'h2AA; tick("R11");
    run_idle("R11", 80); tick("R11");
    check("R11", "entry kept", int'(dac_code), 1023);
    // R10: deselect aborts mid-ramp without done
    cmd_down = 1; tick("R10"); repeat (8) tick("R10");
    ctl_write(mkctl(0, 0, 0, 10'h0F0), "R10");
    check("R10", "static out", int'(dac_code), 10'h0F0);
    tick("R10");
    check("R10", "aborted", int'(busy), 0);

    // random stretch with fresh profile contents
    for (int i = 0; i < 64; i++) begin
      ram_we = 1; ram_waddr = 6'(i); ram_wdata = 10'($urandom); tick("R2");
    end
    ctl_write(mkctl(1, 0, 0, 10'h000), "R6");
    for (int i = 0; i < 6000; i++) begin
      int r;
      r = int'($urandom % 100);
      step_en = ($urandom % 4) != 0;
      cmd_up = (r < 3); cmd_down = (r >= 3 && r < 6); cmd_cycle = (r == 6);
      if (r == 7) begin ctl_we = 1; ctl_wdata = mkctl($urandom % 8 != 0, $urandom % 3 == 0,
                                                         $urandom % 2 == 1, 10'($urandom)); end
      if (r == 8) begin ram_we = 1; ram_waddr = 6'($urandom); ram_wdata = 10'($urandom); end
      tick("R7/R8/R9");
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule